// File: doc/BRIEF.md
# Involutional SPN Round Datapath

This block is an iterative 64-bit substitution-permutation cipher core that finishes one full round on every clock. A start pulse captures a 64-bit block and passes it through an initial layer of nibble substitution. The core then runs 34 rounds. In each round it transposes the state bits, XORs a 64-bit round key into the state and substitutes every nibble. When round 34 is complete it raises done for one cycle, and the result stays on its output until the next start.

The core does not generate keys. A round index output tells an external key source which round key to present, and the core samples that key in the same cycle. The substitution box and the bit transposition are each their own inverse. Because of this, one unchanged datapath handles both directions. Encryption is fed keys K1 to K34. Decryption is fed the transposed keys P(K34) down to P(K1) and returns the original block.

Top module: `spn_round_core`

## Requirements
- R1: While rst_n is low and after it is released, data_out is 0, round_idx is 0, busy is 0 and done is 0 until a start is accepted.
- R2: A start pulse that arrives while busy is 0 loads S(data_in) into the state at that clock edge, sets busy to 1 and sets round_idx to 1.
- R3: On each clock edge where busy is 1, the state becomes S(P(state) XOR round_key), using the round_key that is present in that cycle.
- R4: S works on each of the 16 nibbles on its own (nibble k is bits 4k+3..4k) and maps hex 0..F to D,7,3,2,9,A,C,1,F,4,5,E,6,0,B,8.
- R5: P is a fixed transposition that uses 1-indexed positions, where position p is vector bit p-1. Input position i goes to output position P(i). For example 1→13, 2→2, 3→60, 4→50, 5→51, 6→27, 7→10 and 8→36, and P applied twice is the identity.
- R6: While busy is 1, round_idx takes the values 1 to 34 in order, moving up by one per clock.
- R7: done is 1 for exactly one cycle, the cycle after round 34. From that cycle until the next accepted start, data_out holds the result unchanged.
- R8: A start pulse while busy is 1 is ignored: the round sequence and the result are not affected.
- R9: If the ciphertext is run back through the core with round keys P(K34) down to P(K1), the core returns the original plaintext.
- R10: busy is 1 from the cycle after an accepted start through the cycle in which round 34 is computed, and is 0 at all other times. round_idx is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new block when idle |
| data_in | input | 64 | Block to process, sampled with start |
| round_key | input | 64 | Key for the round named by round_idx |
| data_out | output | 64 | Cipher state; the result once done is raised |
| round_idx | output | 6 | Current round 1..34, or 0 when idle |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The bench runs a set of blocks that includes the all-zero block, the all-one block and walking-bit patterns. It checks each ciphertext against a model built from the S and P tables. This model catches a wrong S-box entry, a mirrored permutation index, or keys applied after the substitution instead of before it. It then decrypts every ciphertext with the transposed, reversed keys and expects the plaintext back. A datapath that is not a true involution, or a key source that is off by one round, gives back garbage. Every cycle, round_idx is compared against the expected count, so a counter that skips a round or stops at 33 or 35 is caught. A start pulse is injected in the middle of a run, which exposes a design that restarts. After done, the bench checks that done falls and that the result stays constant.

// File: rtl/spn_round_core.sv
module spn_round_core #(
  parameter int ROUNDS = 34,
  localparam int IW = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [63:0]   data_in,
  input  logic [63:0]   round_key,
  output logic [63:0]   data_out,
  output logic [IW-1:0] round_idx,
  output logic          busy,
  output logic          done
);

  localparam logic [3:0] SBOX [16] = '{
    4'hD, 4'h7, 4'h3, 4'h2, 4'h9, 4'hA, 4'hC, 4'h1,
    4'hF, 4'h4, 4'h5, 4'hE, 4'h6, 4'h0, 4'hB, 4'h8
  };

  localparam int PMAP [64] = '{
    13,  2, 60, 50, 51, 27, 10, 36,
    25,  7, 32, 61,  1, 49, 47, 19,
    34, 53, 16, 22, 57, 20, 48, 41,
     9, 52,  6, 31, 62, 30, 28, 11,
    37, 17, 58,  8, 33, 44, 46, 59,
    24, 55, 63, 38, 56, 39, 15, 23,
    14,  4,  5, 26, 18, 54, 42, 45,
    21, 35, 40,  3, 12, 29, 43, 64
  };

  function automatic logic [63:0] sub_layer(input logic [63:0] x);
    logic [63:0] y;
    for (int k = 0; k < 16; k++) y[4*k +: 4] = SBOX[x[4*k +: 4]];
    return y;
  endfunction

  function automatic logic [63:0] perm_layer(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[PMAP[i]-1] = x[i];
    return y;
  endfunction

  logic [63:0] state_q;
  logic [63:0] round_nxt;
  logic        last_rnd;

  assign round_nxt = sub_layer(perm_layer(state_q) ^ round_key);
  assign last_rnd  = (round_idx == IW'(ROUNDS));
  assign data_out  = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= '0;
      round_idx <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        state_q <= round_nxt;
        if (last_rnd) begin
          busy      <= 1'b0;
          round_idx <= '0;
          done      <= 1'b1;
        end else begin
          round_idx <= round_idx + 1'b1;
        end
      end else if (start) begin
        state_q   <= sub_layer(data_in);
        busy      <= 1'b1;
        round_idx <= IW'(1);
      end
    end
  end

endmodule

// File: rtl/spn_round_core_chk.sv
module spn_round_core_chk #(
  parameter int ROUNDS = 34,
  localparam int IW = $clog2(ROUNDS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [63:0]   data_out,
  input logic [IW-1:0] round_idx,
  input logic          busy,
  input logic          done
);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && round_idx == IW'(1));

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && round_idx != IW'(ROUNDS) |=> round_idx == $past(round_idx) + 1'b1);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && round_idx == IW'(ROUNDS) |=> done && !busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(data_out));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && round_idx != IW'(ROUNDS) |=> busy && round_idx != IW'(1));

  // R10
  idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> round_idx == '0);

endmodule

bind spn_round_core spn_round_core_chk #(.ROUNDS(ROUNDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .data_out(data_out),
  .round_idx(round_idx), .busy(busy), .done(done)
);

// File: tb/spn_round_core_tb_top.sv
module spn_round_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] data_in = '0;
  logic [63:0] round_key;
  logic [63:0] data_out;
  logic [5:0]  round_idx;
  logic        busy, done;

  int checks = 0;
  int fails = 0;
  logic        dec_mode = 1'b0;
  logic [63:0] seed = '0;

  always #5 clk = ~clk;

  spn_round_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
    .round_key(round_key), .data_out(data_out), .round_idx(round_idx),
    .busy(busy), .done(done)
  );

  localparam logic [3:0] SB [16] = '{
    4'hD, 4'h7, 4'h3, 4'h2, 4'h9, 4'hA, 4'hC, 4'h1,
    4'hF, 4'h4, 4'h5, 4'hE, 4'h6, 4'h0, 4'hB, 4'h8
  };
  localparam int PT [64] = '{
    13,  2, 60, 50, 51, 27, 10, 36, 25,  7, 32, 61,  1, 49, 47, 19,
    34, 53, 16, 22, 57, 20, 48, 41,  9, 52,  6, 31, 62, 30, 28, 11,
    37, 17, 58,  8, 33, 44, 46, 59, 24, 55, 63, 38, 56, 39, 15, 23,
    14,  4,  5, 26, 18, 54, 42, 45, 21, 35, 40,  3, 12, 29, 43, 64
  };

  function automatic logic [63:0] m_sub(input logic [63:0] x);
    logic [63:0] y;
    for (int k = 0; k < 16; k++) y[4*k +: 4] = SB[x[4*k +: 4]];
    return y;
  endfunction

  function automatic logic [63:0] m_perm(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[PT[i]-1] = x[i];
    return y;
  endfunction

  function automatic logic [63:0] key_of(input logic [63:0] s, input int r);
    logic [63:0] m;
    m = s ^ (64'(r) * 64'h9E3779B97F4A7C15);
    return {m[40:0], m[63:41]} ^ 64'(r);
  endfunction

  function automatic logic [63:0] model(input logic [63:0] blk, input logic dec,
                                        input logic [63:0] s);
    logic [63:0] st;
    st = m_sub(blk);
    for (int r = 1; r <= 34; r++)
      st = m_sub(m_perm(st) ^ (dec ? m_perm(key_of(s, 35 - r)) : key_of(s, r)));
    return st;
  endfunction

  always_comb begin
    if (round_idx >= 6'd1 && round_idx <= 6'd34)
      round_key = dec_mode ? m_perm(key_of(seed, 35 - int'(round_idx)))
                           : key_of(seed, int'(round_idx));
    else
      round_key = '0;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] blk, input logic dec, input bit poke,
                     output logic [63:0] res);
    logic [63:0] exp_v;
    bit idx_ok;
    exp_v = model(blk, dec, seed);
    @(negedge clk);
    dec_mode = dec;
    data_in = blk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(data_out == m_sub(blk), "R2 initial substitution", data_out, m_sub(blk));
    idx_ok = 1'b1;
    for (int r = 1; r <= 34; r++) begin
      if (round_idx != 6'(r) || !busy) begin
        idx_ok = 1'b0;
        check(1'b0, "R6/R10 round index", 64'(round_idx), 64'(r));
      end
      if (poke && r == 12) begin
        data_in = ~blk;
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      data_in = blk;
    end
    check(idx_ok, "R6 index sequence 1..34", 64'(idx_ok), 64'd1);
    check(done && !busy && round_idx == 6'd0, "R7 R10 done after round 34",
          {busy, done, round_idx}, {2'b01, 6'd0});
    check(data_out == exp_v, dec ? "R3 R4 R5 decrypt model" : "R3 R4 R5 encrypt model",
          data_out, exp_v);
    if (poke) check(data_out == exp_v, "R8 mid-run start ignored", data_out, exp_v);
    res = data_out;
    @(negedge clk);
    check(!done, "R7 done one cycle", 64'(done), 64'd0);
    check(data_out == res, "R7 result held", data_out, res);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] pats [10];
    logic [63:0] ct, pt;
    pats = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
             64'h1, 64'h8000_0000_0000_0000, 64'h0000_0001_0000_0000,
             64'hA5A5_5A5A_F00F_0FF0, 64'hDEAD_BEEF_CAFE_F00D,
             64'h0000_0000_0000_0010, 64'h7FFF_FFFF_FFFF_FFFE};
    repeat (3) @(negedge clk);
    check(data_out == 0 && round_idx == 0 && !busy && !done, "R1 reset state",
          data_out, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(data_out == 0 && round_idx == 0 && !busy && !done, "R1 idle after reset",
          {data_out[55:0], round_idx, busy, done}, 64'd0);
    for (int i = 0; i < 10; i++) begin
      seed = 64'h1357_9BDF_2468_ACE0 ^ (64'(i) << (6 * i));
      run(pats[i], 1'b0, (i % 3) == 1, ct);
      run(ct, 1'b1, (i % 4) == 2, pt);
      check(pt == pats[i], "R9 decrypt returns plaintext", pt, pats[i]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule